// File: doc/BRIEF.md
# I2C Slave Receiver with Byte-Wide Status Codes

This block is the receive side of an I2C target, built for a controller that software drives one event at a time. It oversamples SCL and SDA with the system clock and detects START and STOP conditions. It collects the first byte after each START as an address. It answers its own 7-bit address with the write direction and, if software enables it, the all-zero general call. For every byte it accepts, it returns ACK or NACK on the ninth clock, depending on a software-owned acknowledge-enable bit.

Each completed byte slot ends in a fixed 8-bit status code and a raised service flag. The block holds SCL low for as long as that flag is set, so the bus master waits until software has read the code and the received byte. Software then chooses the next acknowledge value and whether a START should be requested later, and clears the flag to let the transfer continue.

Arbitration itself is handled elsewhere. A one-cycle `arb_lost_i` pulse only tells this block to report the combined codes when it is addressed next.

Top module: `i2c_slave_rx`

## Requirements
- R1: After reset, the status is 0xF8, the service flag (SI) is 0, the data register is 0x00, `start_req_o` is 0, and neither SCL nor SDA is driven.
- R2: A first byte after START with bits 7:1 equal to address-register bits 7:1 and bit 0 = 0 (write) is ACKed while AA = 1. It gives status 0x60, or 0x68 if an `arb_lost_i` pulse occurred since the last acknowledged address.
- R3: A first byte of 0x00 is ACKed only when address-register bit 0 = 1 and AA = 1. It gives status 0x70, or 0x78 after an arbitration-lost pulse. Otherwise it is NACKed and SI stays 0.
- R4: A first byte whose 7-bit address differs from the block's own, or whose bit 0 = 1 (read), is NACKed and leaves SI at 0 and the status at 0xF8.
- R5: A data byte received under the block's own address is ACKed with status 0x80 when AA = 1. It is NACKed with status 0x88 when AA = 0. The byte is on `data_o` when SI rises.
- R6: A data byte received under general call gives status 0x90 with ACK (AA = 1) or 0x98 with NACK (AA = 0).
- R7: SI is set on the SCL falling edge that ends the ninth (acknowledge) clock. SCL is held low while SI = 1 and released once SI is cleared.
- R8: Register writes use `reg_sel` 0 for the address register, 1 for control and 2 for data. Control bit 0 is AA, bit 1 is STA and bit 2 is SI. Writing 0 to SI clears it and sets the status to 0xF8; writing 1 to SI has no effect.
- R9: When SI is cleared after status 0x88 or 0x98, the block is no longer addressed: further bytes get no ACK and no SI until a new START. With AA = 0, even its own address is NACKed.
- R10: If STA = 1 is written in the same control write that clears SI after 0x88 or 0x98, `start_req_o` asserts once a STOP has left the bus free. It drops when STA is written 0.
- R11: Writes to the data register are ignored while the block is receiving an address or is addressed. They take effect while it is not addressed.
- R12: A STOP while addressed returns the block to not-addressed mode, so bytes without a new START are NACKed. A repeated START restarts address recognition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| arb_lost_i | input | 1 | One-cycle pulse: arbitration lost during own address phase as master |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 control, 2 data |
| reg_wdata | input | 8 | Register write data |
| scl_oe_o | output | 1 | Pull SCL low (clock stretch) |
| sda_oe_o | output | 1 | Pull SDA low (acknowledge) |
| si_o | output | 1 | Service flag |
| status_o | output | 8 | Status code |
| data_o | output | 8 | Data register |
| start_req_o | output | 1 | Request to send START when the bus is free |

## Verification
The hardest state to reach is the exit to not-addressed mode with a queued START request. It needs a matched address, a data byte NACKed because AA was cleared one byte earlier, and then a single control write that clears SI while setting STA. Only after that does the request appear, and only after the following STOP. The bench reaches this state with an open-drain bus master model that honours clock stretching. The bench sequences the control writes between bytes, and it checks `start_req_o` both before and after the STOP. Mid-byte STOPs and repeated STARTs are produced by breaking off a byte after four clocks.

// File: rtl/i2c_srx_pkg.sv
package i2c_srx_pkg;

  localparam logic [7:0] ST_OWN_W     = 8'h60;
  localparam logic [7:0] ST_OWN_W_ARB = 8'h68;
  localparam logic [7:0] ST_GC        = 8'h70;
  localparam logic [7:0] ST_GC_ARB    = 8'h78;
  localparam logic [7:0] ST_OWN_ACK   = 8'h80;
  localparam logic [7:0] ST_OWN_NACK  = 8'h88;
  localparam logic [7:0] ST_GC_ACK    = 8'h90;
  localparam logic [7:0] ST_GC_NACK   = 8'h98;
  localparam logic [7:0] ST_NONE      = 8'hF8;

  localparam logic [1:0] SEL_ADR  = 2'd0;
  localparam logic [1:0] SEL_CTRL = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  localparam int CB_AA  = 0;
  localparam int CB_STA = 1;
  localparam int CB_SI  = 2;

  typedef enum logic [2:0] {
    SM_IDLE,
    SM_ADDR,
    SM_OWN,
    SM_GC,
    SM_SKIP
  } srx_mode_e;

  function automatic logic own_hit(input logic [7:0] rx, input logic [7:0] adr);
    return (rx[7:1] == adr[7:1]) && !rx[0];
  endfunction

  function automatic logic gc_hit(input logic [7:0] rx, input logic [7:0] adr);
    return (rx == 8'h00) && adr[0];
  endfunction

  function automatic logic [7:0] addr_code(input logic gc, input logic arb);
    if (gc) return arb ? ST_GC_ARB : ST_GC;
    return arb ? ST_OWN_W_ARB : ST_OWN_W;
  endfunction

  function automatic logic [7:0] data_code(input logic gc, input logic ack);
    if (gc) return ack ? ST_GC_ACK : ST_GC_NACK;
    return ack ? ST_OWN_ACK : ST_OWN_NACK;
  endfunction

endpackage

// File: rtl/i2c_srx_linemon.sv
module i2c_srx_linemon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev,
  output logic sda_level
);
  logic [SYNC_STAGES:0] scl_q;
  logic [SYNC_STAGES:0] sda_q;
  logic scl_cur, scl_prev, sda_cur, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[SYNC_STAGES-1:0], scl_i};
      sda_q <= {sda_q[SYNC_STAGES-1:0], sda_i};
    end
  end

  assign scl_cur  = scl_q[SYNC_STAGES-1];
  assign scl_prev = scl_q[SYNC_STAGES];
  assign sda_cur  = sda_q[SYNC_STAGES-1];
  assign sda_prev = sda_q[SYNC_STAGES];

  assign scl_rise  = scl_cur & ~scl_prev;
  assign scl_fall  = ~scl_cur & scl_prev;
  assign start_ev  = scl_cur & scl_prev & sda_prev & ~sda_cur;
  assign stop_ev   = scl_cur & scl_prev & ~sda_prev & sda_cur;
  assign sda_level = sda_cur;
endmodule

// File: rtl/i2c_srx_shifter.sv
module i2c_srx_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            active,
  input  logic            rise,
  input  logic            fall,
  input  logic            sda,
  output logic [BITS-1:0] rx_byte,
  output logic            byte_end,
  output logic            slot_end,
  output logic            in_ack
);
  localparam int CW = $clog2(BITS + 2);
  localparam logic [CW-1:0] LAST_BIT = CW'(BITS);
  localparam logic [CW-1:0] ACK_BIT  = CW'(BITS + 1);

  logic [CW-1:0] cnt;

  assign byte_end = active & fall & (cnt == LAST_BIT) & ~in_ack;
  assign slot_end = active & fall & (cnt == ACK_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      in_ack  <= 1'b0;
      rx_byte <= '0;
    end else if (restart || !active) begin
      cnt    <= '0;
      in_ack <= 1'b0;
    end else begin
      if (rise && cnt < LAST_BIT) begin
        rx_byte <= {rx_byte[BITS-2:0], sda};
        cnt     <= cnt + 1'b1;
      end else if (rise && in_ack && cnt == LAST_BIT) begin
        cnt <= ACK_BIT;
      end
      if (byte_end) in_ack <= 1'b1;
      if (slot_end) begin
        cnt    <= '0;
        in_ack <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
  import i2c_srx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DW          = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          arb_lost_i,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic          scl_oe_o,
  output logic          sda_oe_o,
  output logic          si_o,
  output logic [DW-1:0] status_o,
  output logic [DW-1:0] data_o,
  output logic          start_req_o
);
  logic scl_rise_w, scl_fall_w, start_w, stop_w, sda_w;
  logic byte_end_w, slot_end_w, in_ack_w;
  logic [DW-1:0] rx_byte_w;

  srx_mode_e mode_q, next_mode_q;
  logic [DW-1:0] adr_q, code_q;
  logic aa_q, sta_q, si_q, ack_val_q, nack_exit_q, arb_q, start_pend_q, busy_q;

  logic ctrl_wr_w, data_wr_w, si_clear_w, receiving_w;

  assign ctrl_wr_w   = reg_we && reg_sel == SEL_CTRL;
  assign data_wr_w   = reg_we && reg_sel == SEL_DATA;
  assign si_clear_w  = ctrl_wr_w && !reg_wdata[CB_SI] && si_q;
  assign receiving_w = mode_q == SM_ADDR || mode_q == SM_OWN || mode_q == SM_GC;

  i2c_srx_linemon #(.SYNC_STAGES(SYNC_STAGES)) u_linemon (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise_w),
    .scl_fall  (scl_fall_w),
    .start_ev  (start_w),
    .stop_ev   (stop_w),
    .sda_level (sda_w)
  );

  i2c_srx_shifter #(.BITS(DW)) u_shifter (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (start_w),
    .active   (receiving_w),
    .rise     (scl_rise_w),
    .fall     (scl_fall_w),
    .sda      (sda_w),
    .rx_byte  (rx_byte_w),
    .byte_end (byte_end_w),
    .slot_end (slot_end_w),
    .in_ack   (in_ack_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adr_q        <= '0;
      aa_q         <= 1'b0;
      sta_q        <= 1'b0;
      si_q         <= 1'b0;
      code_q       <= ST_NONE;
      status_o     <= ST_NONE;
      data_o       <= '0;
      mode_q       <= SM_IDLE;
      next_mode_q  <= SM_IDLE;
      ack_val_q    <= 1'b0;
      nack_exit_q  <= 1'b0;
      arb_q        <= 1'b0;
      start_pend_q <= 1'b0;
      busy_q       <= 1'b0;
    end else begin
      if (reg_we && reg_sel == SEL_ADR) adr_q <= reg_wdata;
      if (ctrl_wr_w) begin
        aa_q  <= reg_wdata[CB_AA];
        sta_q <= reg_wdata[CB_STA];
        if (!reg_wdata[CB_STA]) start_pend_q <= 1'b0;
      end
      if (data_wr_w && !receiving_w) data_o <= reg_wdata;
      if (arb_lost_i) arb_q <= 1'b1;

      if (start_w) begin
        busy_q    <= 1'b1;
        mode_q    <= SM_ADDR;
        ack_val_q <= 1'b0;
      end else if (stop_w) begin
        busy_q    <= 1'b0;
        mode_q    <= SM_IDLE;
        ack_val_q <= 1'b0;
      end else if (byte_end_w) begin
        case (mode_q)
          SM_ADDR: begin
            if (aa_q && own_hit(rx_byte_w, adr_q)) begin
              ack_val_q   <= 1'b1;
              code_q      <= addr_code(1'b0, arb_q);
              next_mode_q <= SM_OWN;
            end else if (aa_q && gc_hit(rx_byte_w, adr_q)) begin
              ack_val_q   <= 1'b1;
              code_q      <= addr_code(1'b1, arb_q);
              next_mode_q <= SM_GC;
            end else begin
              ack_val_q <= 1'b0;
              mode_q    <= SM_SKIP;
            end
          end
          SM_OWN, SM_GC: begin
            data_o      <= rx_byte_w;
            ack_val_q   <= aa_q;
            code_q      <= data_code(mode_q == SM_GC, aa_q);
            nack_exit_q <= !aa_q;
          end
          default: ack_val_q <= 1'b0;
        endcase
      end else if (slot_end_w) begin
        si_q      <= 1'b1;
        status_o  <= code_q;
        ack_val_q <= 1'b0;
        if (mode_q == SM_ADDR) begin
          mode_q <= next_mode_q;
          arb_q  <= arb_lost_i;
        end
      end

      if (si_clear_w) begin
        si_q     <= 1'b0;
        status_o <= ST_NONE;
        if (nack_exit_q) begin
          mode_q      <= SM_IDLE;
          nack_exit_q <= 1'b0;
          if (reg_wdata[CB_STA]) start_pend_q <= 1'b1;
        end
      end
    end
  end

  assign si_o        = si_q;
  assign scl_oe_o    = si_q;
  assign sda_oe_o    = in_ack_w & ack_val_q;
  assign start_req_o = start_pend_q & ~busy_q & sta_q;
endmodule

// File: rtl/i2c_slave_rx_chk.sv
module i2c_slave_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       si_o,
  input logic       sda_oe_o,
  input logic       scl_oe_o,
  input logic [7:0] status_o,
  input logic [7:0] data_o,
  input logic       scl_fall_w,
  input logic       byte_end_w,
  input logic       data_wr_w,
  input logic       receiving_w,
  input logic       start_req_o
);
  // R7
  si_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(si_o) |-> $past(scl_fall_w));

  // R5
  ack_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(si_o) && (status_o == 8'h60 || status_o == 8'h68 || status_o == 8'h70 ||
                    status_o == 8'h78 || status_o == 8'h80 || status_o == 8'h90)
    |-> $past(sda_oe_o));

  // R6
  nack_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(si_o) && (status_o == 8'h88 || status_o == 8'h98) |-> !$past(sda_oe_o));

  // R8
  clear_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(si_o) |-> status_o == 8'hF8);

  // R11
  data_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_o) |-> $past(byte_end_w) || ($past(data_wr_w) && !$past(receiving_w)));

  // R10
  start_req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_req_o |-> !si_o && !scl_oe_o);
endmodule

bind i2c_slave_rx i2c_slave_rx_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .si_o        (si_o),
  .sda_oe_o    (sda_oe_o),
  .scl_oe_o    (scl_oe_o),
  .status_o    (status_o),
  .data_o      (data_o),
  .scl_fall_w  (scl_fall_w),
  .byte_end_w  (byte_end_w),
  .data_wr_w   (data_wr_w),
  .receiving_w (receiving_w),
  .start_req_o (start_req_o)
);

// File: tb/i2c_slave_rx_bench.sv
module i2c_slave_rx_bench;
  localparam int Q = 20;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, arb = 1'b0, we = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [7:0] wd = 8'd0;
  logic scl_oe, sda_oe, si, start_req;
  logic [7:0] status, data;
  wire scl_line = scl_m & ~scl_oe;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, errors = 0;
  logic done = 1'b0;

  i2c_slave_rx u_i2c_slave_rx (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .arb_lost_i(arb), .reg_we(we), .reg_sel(sel), .reg_wdata(wd),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .si_o(si), .status_o(status),
    .data_o(data), .start_req_o(start_req)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); we = 1'b1; sel = s; wd = d;
    @(negedge clk); we = 1'b0;
    tick(2);
  endtask

  task automatic pulse_arb();
    @(negedge clk); arb = 1'b1;
    @(negedge clk); arb = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; wait (scl_line === 1'b1); tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; wait (scl_line === 1'b1); tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; wait (scl_line === 1'b1); tick(Q);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; wait (scl_line === 1'b1); tick(Q / 2);
    ack = !sda_line; tick(Q / 2);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic test_reset();
    check("R1 status", status, 8'hF8);
    check("R1 si", si, 0);
    check("R1 data", data, 8'h00);
    check("R1 lines", {scl_oe, sda_oe, start_req}, 3'b000);
  endtask

  task automatic test_own_flow();
    logic ack;
    wr(2'd0, 8'hB4);
    wr(2'd1, 8'h01);
    bus_start(); send_byte(8'hB4, ack);
    check("R2 ack", ack, 1);
    check("R2 status", status, 8'h60);
    check("R7 si", si, 1);
    check("R7 stretch", scl_oe, 1);
    wr(2'd2, 8'hEE);
    check("R11 ignored", data, 8'h00);
    wr(2'd1, 8'h05);
    check("R8 si one no effect", si, 1);
    wr(2'd1, 8'h01);
    check("R8 si", si, 0);
    check("R8 status", status, 8'hF8);
    check("R7 release", scl_oe, 0);
    send_byte(8'hC3, ack);
    check("R5 ack", ack, 1);
    check("R5 status", status, 8'h80);
    check("R5 data", data, 8'hC3);
    wr(2'd1, 8'h00);
    send_byte(8'h3C, ack);
    check("R5 nack", ack, 0);
    check("R5 status nack", status, 8'h88);
    check("R5 data nack", data, 8'h3C);
    wr(2'd1, 8'h01);
    send_byte(8'h77, ack);
    check("R9 no ack", ack, 0);
    check("R9 no si", si, 0);
    check("R9 data kept", data, 8'h3C);
    bus_stop();
    wr(2'd2, 8'h5A);
    check("R11 idle write", data, 8'h5A);
  endtask

  task automatic test_gc();
    logic ack;
    wr(2'd0, 8'hB5);
    bus_start(); send_byte(8'h00, ack);
    check("R3 ack", ack, 1);
    check("R3 status", status, 8'h70);
    wr(2'd1, 8'h01);
    send_byte(8'h11, ack);
    check("R6 ack", ack, 1);
    check("R6 status", status, 8'h90);
    check("R6 data", data, 8'h11);
    wr(2'd1, 8'h00);
    send_byte(8'h22, ack);
    check("R6 nack", ack, 0);
    check("R6 status nack", status, 8'h98);
    wr(2'd1, 8'h01);
    bus_stop();
    wr(2'd0, 8'hB4);
    bus_start(); send_byte(8'h00, ack);
    check("R3 disabled nack", ack, 0);
    check("R3 disabled si", si, 0);
    bus_stop();
  endtask

  task automatic test_reject();
    logic ack;
    bus_start(); send_byte(8'hB6, ack);
    check("R4 other addr", ack, 0);
    check("R4 si", si, 0);
    check("R4 status", status, 8'hF8);
    bus_stop();
    bus_start(); send_byte(8'hB5, ack);
    check("R4 read dir", ack, 0);
    bus_stop();
    wr(2'd1, 8'h00);
    bus_start(); send_byte(8'hB4, ack);
    check("R9 aa off own", ack, 0);
    check("R9 aa off si", si, 0);
    bus_stop();
    wr(2'd1, 8'h01);
  endtask

  task automatic test_arb();
    logic ack;
    pulse_arb();
    bus_start(); send_byte(8'hB4, ack);
    check("R2 arb status", status, 8'h68);
    wr(2'd1, 8'h01); bus_stop();
    bus_start(); send_byte(8'hB4, ack);
    check("R2 arb cleared", status, 8'h60);
    wr(2'd1, 8'h01); bus_stop();
    wr(2'd0, 8'hB5);
    pulse_arb();
    bus_start(); send_byte(8'h00, ack);
    check("R3 arb status", status, 8'h78);
    wr(2'd1, 8'h01); bus_stop();
    wr(2'd0, 8'hB4);
  endtask

  task automatic test_sta();
    logic ack;
    bus_start(); send_byte(8'hB4, ack);
    wr(2'd1, 8'h00);
    send_byte(8'h44, ack);
    check("R10 nack code", status, 8'h88);
    wr(2'd1, 8'h03);
    check("R10 busy no req", start_req, 0);
    bus_stop();
    tick(5);
    check("R10 req after stop", start_req, 1);
    wr(2'd1, 8'h01);
    check("R10 req dropped", start_req, 0);
  endtask

  task automatic test_stop_restart();
    logic ack;
    bus_start(); send_byte(8'hB4, ack);
    wr(2'd1, 8'h01);
    for (int i = 0; i < 4; i++) begin
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; wait (scl_line === 1'b1); tick(Q);
      scl_m = 1'b0;
    end
    bus_stop();
    check("R12 stop status", status, 8'hF8);
    scl_m = 1'b0; tick(Q);
    send_byte(8'hB4, ack);
    check("R12 idle after stop", ack, 0);
    check("R12 idle si", si, 0);
    bus_stop();
    bus_start(); send_byte(8'hB4, ack);
    wr(2'd1, 8'h01);
    send_byte(8'h55, ack);
    check("R12 pre data", status, 8'h80);
    wr(2'd1, 8'h01);
    bus_start(); send_byte(8'hB4, ack);
    check("R12 restart ack", ack, 1);
    check("R12 restart status", status, 8'h60);
    wr(2'd1, 8'h01);
    bus_stop();
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(3);
    test_reset();
    test_own_flow();
    test_gc();
    test_reject();
    test_arb();
    test_sta();
    test_stop_restart();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule